// File: doc/BRIEF.md
# Dual-Channel Phase Delay Generator

This block sets the conversion-window timing for two decimating channels whose modulators sample at the same instants. A free-running counter on the decimator clock counts modulo a selectable decimation ratio. Channel 1 is the fixed timing reference, and its averaging window always opens at count zero. Channel 0's window opens at an offset taken from a signed phase setting. A positive setting makes channel 0 lag the reference, and a negative setting makes it lead.

For each channel the block gives a window-start strobe and a one-cycle data-ready pulse. The data-ready pulse coincides with a window start, so it marks the end of the window before it. On each data-ready pulse the block captures the filter result presented for that channel and holds it on the channel's code output. A synchronous reset clears the counters, the held codes and the pulse history. A new phase or ratio is only adopted at a reference-window boundary.

Top module: `phase_delay_gen`

## Requirements
- R1: `ratio_sel_i` selects the decimation ratio N (0 gives 32, 1 gives 64, 2 gives 128, 3 gives 256). After reset is released, `ch1_start_o` is high in the first cycle and then once every N cycles.
- R2: The timing of channel 1's strobes and data-ready pulses does not depend on `phase_i`.
- R3: `phase_i` is an 8-bit two's-complement value. With a non-negative value P, `ch0_start_o` is high exactly (P mod N) cycles after each `ch1_start_o`, so channel 0 lags. A result of zero makes the two strobes coincide.
- R4: With a negative value P, `ch0_start_o` is high (N + P) mod N cycles after each `ch1_start_o`. Channel 0 therefore leads the next reference start by |P| cycles, when |P| < N.
- R5: Each data-ready output is a one-cycle pulse in the same cycle as its channel's window start. The cycle distance from a channel-1 pulse to the following channel-0 pulse equals the programmed offset.
- R6: After reset is released, each channel produces no data-ready pulse at its first window start. It pulses at every later window start.
- R7: While `srst` is high, no strobe and no data-ready pulse is produced. From the first clock edge with `srst` high, both code outputs read 0x0000.
- R8: `phase_i` and `ratio_sel_i` are sampled at reset and at the clock edge that ends the last cycle of each reference window. A change made part-way through a window takes effect from the next channel-1 window start.
- R9: On a channel's data-ready pulse, its code output loads that channel's code input. In all other cycles the code output holds its value.
- R10: A phase magnitude of at least N wraps modulo N. With N = 32, +127 gives offset 31 and -128 gives offset 0. With N = 256, the same values give offsets 127 and 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decimator clock |
| srst | input | 1 | Synchronous reset, active high |
| phase_i | input | 8 | Signed phase setting of channel 0 relative to channel 1 |
| ratio_sel_i | input | 2 | Decimation ratio select |
| ch0_code_i | input | 16 | Filter result offered for channel 0 |
| ch1_code_i | input | 16 | Filter result offered for channel 1 |
| ch0_start_o | output | 1 | Channel 0 window-start strobe |
| ch0_drdy_o | output | 1 | Channel 0 data-ready pulse |
| ch0_code_o | output | 16 | Held channel 0 result |
| ch1_start_o | output | 1 | Channel 1 window-start strobe |
| ch1_drdy_o | output | 1 | Channel 1 data-ready pulse |
| ch1_code_o | output | 16 | Held channel 1 result |

## Verification
The hardest case to reach is a phase change that lands in the middle of a reference window. The old offset must stay in force for the rest of that window, and the new one must begin exactly at the next channel-1 start. The stimulus changes `phase_i` two cycles into a chosen window. The scoreboard has already queued data-ready events at the old offset up to that boundary and at the new offset after it. The wrap cases at both ends of the signed range are also covered, at the smallest and at the largest ratio, so that they hit both the fold-to-zero offset and the half-ratio offset.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

   // widest supported ratio is 2**DEC_MAX_LOG
   localparam int unsigned DEC_MIN_LOG = 5;
   localparam int unsigned DEC_MAX_LOG = 8;

   typedef enum logic [1:0] {
      DEC_32  = 2'd0,
      DEC_64  = 2'd1,
      DEC_128 = 2'd2,
      DEC_256 = 2'd3
   } dec_ratio_e;

   function automatic int unsigned ratio_log(input dec_ratio_e sel);
      return DEC_MIN_LOG + int'(sel);
   endfunction

endpackage

// File: rtl/pdg_timebase.sv
module pdg_timebase
   import pdg_pkg::*;
#(
   parameter int unsigned PH_W  = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  logic [PH_W-1:0]  phase_i,
   input  dec_ratio_e       ratio_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] off_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] ph_ext;
   logic [PH_W-1:0]  ph_q;
   dec_ratio_e       ratio_q;
   logic             wrap;

   if (CNT_W < DEC_MAX_LOG) begin : g_bad_cnt
      $error("pdg_timebase: CNT_W too narrow for the largest ratio");
   end

   // sign-extend or truncate the phase to counter width
   if (PH_W >= CNT_W) begin : g_ph_trunc
      assign ph_ext = ph_q[CNT_W-1:0];
   end else begin : g_ph_sext
      assign ph_ext = {{(CNT_W-PH_W){ph_q[PH_W-1]}}, ph_q};
   end

   assign mask  = CNT_W'((1 << ratio_log(ratio_q)) - 1);
   assign wrap  = (cnt_q == mask);
   assign off_o = ph_ext & mask;
   assign cnt_o = cnt_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         cnt_q   <= '0;
         ph_q    <= phase_i;
         ratio_q <= ratio_i;
      end else if (wrap) begin
         cnt_q   <= '0;
         ph_q    <= phase_i;
         ratio_q <= ratio_i;
      end else begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end

   // R1
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (srst)
      cnt_q <= mask);

   // R8
   setting_hold_chk: assert property (@(posedge clk) disable iff (srst)
      !wrap |=> ($stable(ph_q) && $stable(ratio_q)));

endmodule

// File: rtl/pdg_channel.sv
module pdg_channel #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned CODE_W = 16
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  off_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              start_o,
   output logic              drdy_o,
   output logic [CODE_W-1:0] code_o
);

   logic              seen_q;
   logic [CODE_W-1:0] code_q;

   assign start_o = !srst && (cnt_i == off_i);
   assign drdy_o  = start_o && seen_q;
   assign code_o  = code_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         seen_q <= 1'b0;
         code_q <= '0;
      end else begin
         if (start_o) seen_q <= 1'b1;
         if (drdy_o)  code_q <= code_i;
      end
   end

   // R9
   code_hold_chk: assert property (@(posedge clk) disable iff (srst)
      !drdy_o |=> $stable(code_o));

endmodule

// File: rtl/phase_delay_gen.sv
module phase_delay_gen
   import pdg_pkg::*;
#(
   parameter int unsigned PH_W   = 8,
   parameter int unsigned CODE_W = 16
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [PH_W-1:0]   phase_i,
   input  logic [1:0]        ratio_sel_i,
   input  logic [CODE_W-1:0] ch0_code_i,
   input  logic [CODE_W-1:0] ch1_code_i,
   output logic              ch0_start_o,
   output logic              ch0_drdy_o,
   output logic [CODE_W-1:0] ch0_code_o,
   output logic              ch1_start_o,
   output logic              ch1_drdy_o,
   output logic [CODE_W-1:0] ch1_code_o
);

   localparam int unsigned CNT_W = DEC_MAX_LOG;
   localparam int unsigned N_CH  = 2;

   if (PH_W < 2) begin : g_bad_ph
      $error("phase_delay_gen: PH_W must hold a sign and a magnitude");
   end

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  off0;
   logic [CODE_W-1:0] code_in  [N_CH];
   logic [CODE_W-1:0] code_out [N_CH];
   logic              start    [N_CH];
   logic              drdy     [N_CH];

   pdg_timebase #(.PH_W(PH_W), .CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .srst    (srst),
      .phase_i (phase_i),
      .ratio_i (dec_ratio_e'(ratio_sel_i)),
      .cnt_o   (cnt),
      .off_o   (off0)
   );

   assign code_in[0] = ch0_code_i;
   assign code_in[1] = ch1_code_i;

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      logic [CNT_W-1:0] off_k;
      if (k == 1) begin : g_ref
         assign off_k = '0;
      end else begin : g_shift
         assign off_k = off0;
      end
      pdg_channel #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_ch (
         .clk     (clk),
         .srst    (srst),
         .cnt_i   (cnt),
         .off_i   (off_k),
         .code_i  (code_in[k]),
         .start_o (start[k]),
         .drdy_o  (drdy[k]),
         .code_o  (code_out[k])
      );
   end

   assign ch0_start_o = start[0];
   assign ch0_drdy_o  = drdy[0];
   assign ch0_code_o  = code_out[0];
   assign ch1_start_o = start[1];
   assign ch1_drdy_o  = drdy[1];
   assign ch1_code_o  = code_out[1];

   // R7
   reset_clear_chk: assert property (@(posedge clk)
      srst |=> (ch0_code_o == '0 && ch1_code_o == '0));

   // R2
   ref_align_chk: assert property (@(posedge clk) disable iff (srst)
      ch1_start_o |-> (cnt == '0));

   // R5
   ref_pulse_width_chk: assert property (@(posedge clk) disable iff (srst)
      ch1_drdy_o |=> !ch1_drdy_o);

endmodule

// File: tb/tb_phase_delay_gen.sv
module tb_phase_delay_gen;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int cyc;
      int ch;
   } ev_t;

   logic        clk;
   logic        srst;
   logic [7:0]  phase_i;
   logic [1:0]  ratio_sel_i;
   logic [15:0] ch0_code_i, ch1_code_i;
   logic        ch0_start_o, ch0_drdy_o, ch1_start_o, ch1_drdy_o;
   logic [15:0] ch0_code_o, ch1_code_o;

   ev_t exp_q[$];
   int  checks = 0, fails = 0;
   int  cyc = 0;
   int  seg_r = 0, seg_n = 32, seg_off = 0;
   bit  seg_on = 0, seg_chg = 0;

   phase_delay_gen dut (
      .clk(clk), .srst(srst), .phase_i(phase_i), .ratio_sel_i(ratio_sel_i),
      .ch0_code_i(ch0_code_i), .ch1_code_i(ch1_code_i),
      .ch0_start_o(ch0_start_o), .ch0_drdy_o(ch0_drdy_o), .ch0_code_o(ch0_code_o),
      .ch1_start_o(ch1_start_o), .ch1_drdy_o(ch1_drdy_o), .ch1_code_o(ch1_code_o)
   );

   initial begin
      clk = 0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                  req, what, cyc, act, exp);
      end
   endtask

   function automatic int wrap_off(input logic [7:0] ph, input int n);
      int s;
      s = int'($signed(ph));
      return ((s % n) + n) % n;
   endfunction

   // code inputs change every cycle so each capture is distinguishable
   initial begin
      ch0_code_i = 16'h0;
      ch1_code_i = 16'h0;
      forever begin
         @(posedge clk);
         #1;
         ch0_code_i = {cyc[7:0], 8'hA5};
         ch1_code_i = {8'h3C, cyc[7:0]};
      end
   end

   // driver: runs one segment and queues every expected data-ready event
   task automatic run_seg(input logic [7:0] ph_a, input logic [1:0] sel,
                          input int periods, input logic [7:0] ph_b,
                          input int chg_p);
      int n, off_a, off_b;
      n     = 32 << sel;
      off_a = wrap_off(ph_a, n);
      off_b = wrap_off(ph_b, n);
      phase_i     = ph_a;
      ratio_sel_i = sel;
      @(posedge clk);
      #1;
      @(posedge clk);
      #1;
      srst    = 0;
      seg_r   = cyc;
      seg_n   = n;
      seg_off = off_a;
      seg_chg = (chg_p > 0);
      seg_on  = 1;
      for (int p = 1; p < periods; p++) begin
         int o;
         o = (chg_p > 0 && p >= chg_p) ? off_b : off_a;
         exp_q.push_back('{seg_r + p*n, 1});
         exp_q.push_back('{seg_r + p*n + o, 0});
      end
      while (cyc < seg_r + periods*n) begin
         @(posedge clk);
         #1;
         // R8: change mid-window, two cycles into the window before chg_p
         if (chg_p > 0 && cyc == seg_r + (chg_p-1)*n + 2) phase_i = ph_b;
      end
      srst   = 1;
      seg_on = 0;
      repeat (3) @(posedge clk);
      #1;
      // R5: every queued pulse must have been seen
      check(exp_q.size() == 0, "R5", "pulses left unseen", exp_q.size(), 0);
      exp_q.delete();
   endtask

   // monitor: compares outputs with the queue away from the active edge
   initial begin
      bit          prev_srst = 0;
      bit          pend0 = 0, pend1 = 0;
      logic [15:0] pv0 = '0, pv1 = '0;
      forever begin
         @(negedge clk);
         if (pend1) check(ch1_code_o == pv1, "R9", "ch1 code capture", ch1_code_o, pv1);
         if (pend0) check(ch0_code_o == pv0, "R9", "ch0 code capture", ch0_code_o, pv0);
         pend0 = 0;
         pend1 = 0;
         if (srst) begin
            // R7
            check(!ch0_start_o && !ch1_start_o && !ch0_drdy_o && !ch1_drdy_o,
                  "R7", "strobes in reset",
                  int'({ch0_start_o, ch1_start_o, ch0_drdy_o, ch1_drdy_o}), 0);
            if (prev_srst)
               check(ch0_code_o == 16'h0 && ch1_code_o == 16'h0, "R7", "codes in reset",
                     int'(ch0_code_o | ch1_code_o), 0);
         end else if (seg_on) begin
            bit e1, e0;
            // R1 R2
            e1 = ((cyc - seg_r) % seg_n) == 0;
            check(ch1_start_o == e1, "R1", "ch1 start", int'(ch1_start_o), int'(e1));
            if (!seg_chg) begin
               // R3 R4 R10
               e0 = ((cyc - seg_r) % seg_n) == seg_off;
               check(ch0_start_o == e0, "R3", "ch0 start", int'(ch0_start_o), int'(e0));
            end
         end
         while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
            check(0, "R5", "missed pulse", -1, exp_q[0].cyc);
            void'(exp_q.pop_front());
         end
         if (ch1_drdy_o) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc && exp_q[0].ch == 1) begin
               check(1, "R5", "ch1 drdy", cyc, cyc);
               void'(exp_q.pop_front());
            end else
               check(0, "R6", "unexpected ch1 drdy", cyc,
                     exp_q.size() > 0 ? exp_q[0].cyc : -1);
            pend1 = 1;
            pv1   = ch1_code_i;
         end
         if (ch0_drdy_o) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc && exp_q[0].ch == 0) begin
               check(1, "R5", "ch0 drdy", cyc, cyc);
               void'(exp_q.pop_front());
            end else
               check(0, "R6", "unexpected ch0 drdy", cyc,
                     exp_q.size() > 0 ? exp_q[0].cyc : -1);
            pend0 = 1;
            pv0   = ch0_code_i;
         end
         prev_srst = srst;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      srst        = 1;
      phase_i     = 8'h00;
      ratio_sel_i = 2'd0;
      repeat (3) @(posedge clk);
      #1;
      run_seg(8'h00, 2'd0, 5, 8'h00, 0);   // R3 coincident, R6
      run_seg(8'h01, 2'd0, 5, 8'h00, 0);   // R3 lag by one
      run_seg(8'hFF, 2'd0, 5, 8'h00, 0);   // R4 lead by one
      run_seg(8'h7F, 2'd0, 5, 8'h00, 0);   // R10 +127 -> 31
      run_seg(8'h80, 2'd0, 5, 8'h00, 0);   // R10 -128 -> 0
      run_seg(8'hF6, 2'd2, 3, 8'h00, 0);   // R4 ratio 128, lead by ten
      run_seg(8'h7F, 2'd3, 3, 8'h00, 0);   // R10 ratio 256 -> 127
      run_seg(8'h80, 2'd3, 3, 8'h00, 0);   // R10 ratio 256 -> 128
      run_seg(8'h05, 2'd1, 5, 8'h14, 2);   // R8 change 5 -> 20 mid-window
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule